// File: doc/BRIEF.md
# Quadratic Permutation Interleaver Address Generator

This block supplies the interleaved read or write address for a turbo decoder working on one code block. At the start of a block it captures the block length N and the two polynomial coefficients f1 and f2. From then on it delivers P(i) = (f1*i + f2*i^2) mod N for i = 0, 1, 2, ..., giving one address in each cycle in which the consumer asserts the step enable.

The block holds no address table and has no multiplier or divider. It keeps the current address and a running increment. Each step adds the increment to the address, and adds a fixed second-order term to the increment. Every sum is brought back into range by one compare and one conditional subtraction of N. Any block length from 40 to 6144 therefore works from its three parameters alone.

The caller must provide coefficients already reduced below N. After the last address is delivered, the generator returns to idle and waits for the next start pulse.

Top module: `qppAddrGen`

## Requirements
- R1: After reset the block is idle: `busy`, `addrValid` and `addrLast` are all 0.
- R2: A `start` pulse while idle captures `blockLen`, `coefF1` and `coefF2` at that clock edge. From the next cycle `busy` is 1 and `addrOut` is 0, which is P(0).
- R3: While busy, `addrValid` is 1 exactly in the cycles where `stepEn` is 1. The address shown in such a cycle counts as consumed, and the generator moves to the next index at that edge.
- R4: The k-th valid address of a block equals (f1*k + f2*k*k) mod N, for any f1 and f2 below N.
- R5: While busy with `stepEn` at 0, `addrValid` is 0 and `addrOut` and the index hold their values.
- R6: `addrLast` is 1 only together with the valid address for index N-1. In the following cycle `busy` is 0.
- R7: A `start` pulse while busy has no effect. The running sequence continues unchanged with its original length.
- R8: Every address lies below N. For legal turbo-code coefficient pairs, one block produces each value 0..N-1 exactly once.
- R9: Changes to `blockLen`, `coefF1` or `coefF2` after the start edge do not affect the running block.
- R10: Blocks can follow one another with different lengths and coefficients, each correct from its own start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new block (honoured only when idle) |
| stepEn | input | 1 | Consume the current address and advance |
| blockLen | input | 13 | Block length N, sampled at start |
| coefF1 | input | 13 | Linear coefficient f1 (< N), sampled at start |
| coefF2 | input | 13 | Quadratic coefficient f2 (< N), sampled at start |
| addrOut | output | 13 | Current interleaved address P(i) |
| addrValid | output | 1 | Address is consumed this cycle |
| addrLast | output | 1 | Address is the final one of the block |
| busy | output | 1 | A block is in progress |

## Verification
The address register and the increment register feed each other, so any error in either one persists for the rest of the block. A wrong increment shows up at `addrOut` one valid step later. It then skews every address that follows, because the quadratic term keeps accumulating. A wrong reduction produces an address at or above N, or a repeated address, within the first few steps of a short block. A wrong index count moves `addrLast` and the drop of `busy` away from step N-1, and that shift is visible at the end of every block.

// File: rtl/qppPkg.sv
package qppPkg;
  // Strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic load;     // capture block parameters, reset recurrence
    logic advance;  // move recurrence forward one index
  } qppCtrlT;
endpackage

// File: rtl/qppModAdd.sv
// (a + b) mod n for a, b < n: one add, one compare, one conditional subtract
module qppModAdd #(
  parameter int AW = 13
) (
  input  logic [AW-1:0] opA,
  input  logic [AW-1:0] opB,
  input  logic [AW-1:0] modN,
  output logic [AW-1:0] result
);
  localparam int SW = AW + 1;

  logic [SW-1:0] rawSum;
  logic          wraps;

  always_comb begin
    rawSum = {1'b0, opA} + {1'b0, opB};
    wraps  = rawSum >= {1'b0, modN};
    result = wraps ? AW'(rawSum - {1'b0, modN}) : rawSum[AW-1:0];
  end
endmodule

// File: rtl/qppDatapath.sv
module qppDatapath
  import qppPkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  qppCtrlT       ctrl,
  input  logic [AW-1:0] blockLen,
  input  logic [AW-1:0] coefF1,
  input  logic [AW-1:0] coefF2,
  output logic [AW-1:0] addrOut
);
  logic [AW-1:0] nReg;     // captured modulus
  logic [AW-1:0] pReg;     // P(i)
  logic [AW-1:0] gReg;     // increment g(i) = (f1 + f2 + 2*f2*i) mod N
  logic [AW-1:0] dReg;     // second difference (2*f2) mod N
  logic [AW-1:0] gInit;
  logic [AW-1:0] dInit;
  logic [AW-1:0] pNext;
  logic [AW-1:0] gNext;

  // Load-time reductions, taken directly from the inputs
  qppModAdd #(.AW(AW)) uInitG (.opA(coefF1), .opB(coefF2), .modN(blockLen), .result(gInit));
  qppModAdd #(.AW(AW)) uInitD (.opA(coefF2), .opB(coefF2), .modN(blockLen), .result(dInit));

  // Recurrence step
  qppModAdd #(.AW(AW)) uNextP (.opA(pReg), .opB(gReg), .modN(nReg), .result(pNext));
  qppModAdd #(.AW(AW)) uNextG (.opA(gReg), .opB(dReg), .modN(nReg), .result(gNext));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nReg <= '0;
      pReg <= '0;
      gReg <= '0;
      dReg <= '0;
    end else if (ctrl.load) begin
      nReg <= blockLen;
      pReg <= '0;
      gReg <= gInit;
      dReg <= dInit;
    end else if (ctrl.advance) begin
      pReg <= pNext;
      gReg <= gNext;
    end
  end

  assign addrOut = pReg;

  // R2: a load always restarts the sequence at address zero
  a_r2_load_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (pReg == '0));

  // R8: recurrence state stays below the modulus whenever it is consumed
  a_r8_range: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.advance |-> (pReg < nReg && gReg < nReg && dReg < nReg));

  // R9: the modulus changes only on a load
  a_r9_modulus_held: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(nReg));

  // R5: without a strobe the address holds
  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && !ctrl.advance) |=> $stable(pReg));
endmodule

// File: rtl/qppControl.sv
module qppControl
  import qppPkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          stepEn,
  input  logic [AW-1:0] blockLen,
  output qppCtrlT       ctrl,
  output logic          addrValid,
  output logic          addrLast,
  output logic          busy
);
  typedef enum logic {ST_IDLE, ST_RUN} seqStateT;

  seqStateT      state;
  logic [AW-1:0] idx;
  logic [AW-1:0] lastIdx;
  logic          atEnd;

  always_comb begin
    ctrl.load    = (state == ST_IDLE) && start;
    ctrl.advance = (state == ST_RUN) && stepEn;
    atEnd        = (idx == lastIdx);
    addrValid    = ctrl.advance;
    addrLast     = ctrl.advance && atEnd;
    busy         = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      lastIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          idx     <= '0;
          lastIdx <= blockLen - 1'b1;
        end
        ST_RUN: if (stepEn) begin
          if (atEnd) state <= ST_IDLE;
          else       idx   <= idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: the block ends right after its last address
  a_r6_last_idle: assert property (@(posedge clk) disable iff (!rstN)
    addrLast |=> !busy);

  // R5: a stalled cycle keeps the index
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stepEn) |=> (busy && $stable(idx)));

  // R3: each consumed non-final address moves the index by one
  a_r3_index_step: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrLast) |=> (busy && idx == $past(idx) + 1'b1));

  // R7: a start during a block changes neither length nor progress
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !stepEn) |=> (busy && $stable(lastIdx) && $stable(idx)));

  // R2: a start from idle yields a running block at index zero
  a_r2_start_run: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && idx == '0));
endmodule

// File: rtl/qppAddrGen.sv
module qppAddrGen
  import qppPkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          stepEn,
  input  logic [AW-1:0] blockLen,
  input  logic [AW-1:0] coefF1,
  input  logic [AW-1:0] coefF2,
  output logic [AW-1:0] addrOut,
  output logic          addrValid,
  output logic          addrLast,
  output logic          busy
);
  qppCtrlT ctrl;

  qppControl #(.AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .stepEn(stepEn),
    .blockLen(blockLen), .ctrl(ctrl),
    .addrValid(addrValid), .addrLast(addrLast), .busy(busy)
  );

  qppDatapath #(.AW(AW)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .blockLen(blockLen), .coefF1(coefF1), .coefF2(coefF2),
    .addrOut(addrOut)
  );

  // R1: no valid address outside a block
  a_r1_valid_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!addrValid && !addrLast));
endmodule

// File: tb/tb_qppAddrGen.sv
module tb_qppAddrGen;
  localparam int AW = 13;
  localparam int NV = 8;
  // block length, f1, f2, permutation expected, gapped stepping, disturbance
  localparam int VN [NV] = '{40, 48, 56, 64, 104, 40, 1008, 6144};
  localparam int VF1[NV] = '{3, 7, 19, 7, 7, 39, 55, 263};
  localparam int VF2[NV] = '{10, 12, 42, 16, 26, 39, 84, 480};
  localparam bit VPM[NV] = '{1, 1, 1, 1, 1, 0, 1, 1};
  localparam bit VGP[NV] = '{0, 1, 0, 1, 0, 1, 0, 0};
  localparam bit VDS[NV] = '{0, 0, 1, 0, 1, 0, 1, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic stepEn = 1'b0;
  logic [AW-1:0] blockLen = '0;
  logic [AW-1:0] coefF1 = '0;
  logic [AW-1:0] coefF2 = '0;
  logic [AW-1:0] addrOut;
  logic addrValid, addrLast, busy;

  int checks = 0;
  int errors = 0;
  bit seen [0:6143];

  always #10 clk = ~clk;

  qppAddrGen #(.AW(AW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .stepEn(stepEn),
    .blockLen(blockLen), .coefF1(coefF1), .coefF2(coefF2),
    .addrOut(addrOut), .addrValid(addrValid), .addrLast(addrLast), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runBlock(input int n, input int f1, input int f2,
                          input bit perm, input bit gap, input bit disturb);
    int i;
    int cyc;
    longint expAddr;
    for (int k = 0; k < 6144; k++) seen[k] = 1'b0;
    @(negedge clk);
    blockLen = AW'(n); coefF1 = AW'(f1); coefF2 = AW'(f2);
    stepEn = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(addrOut == '0, "R2 first address", addrOut, 0);
    i = 0; cyc = 0;
    while (i < n) begin
      @(negedge clk);
      stepEn = gap ? ((cyc % 3) != 1) : 1'b1;
      start = disturb && (cyc == 5);
      if (disturb && cyc == 4) begin
        blockLen = 13'd17; coefF1 = 13'd5; coefF2 = 13'd9;  // R9 late changes
      end
      #1;
      expAddr = (longint'(f1) * i + longint'(f2) * i * i) % n;
      if (stepEn) begin
        check(addrValid == 1'b1, "R3 valid on step", addrValid, 1);
        check(addrOut == AW'(expAddr), "R4 address value", addrOut, expAddr);
        check(addrLast == (i == n - 1), "R6 last flag", addrLast, (i == n - 1));
        check(addrOut < AW'(n), "R8 address below N", addrOut, n);
        if (addrOut < 6144) begin
          if (perm) check(!seen[addrOut], "R8 address repeated", addrOut, -1);
          seen[addrOut] = 1'b1;
        end
        i++;
      end else begin
        check(addrValid == 1'b0 && addrLast == 1'b0, "R5 no valid on stall", addrValid, 0);
        check(addrOut == AW'(expAddr), "R5 address held", addrOut, expAddr);
      end
      if (disturb && cyc == 6) check(busy == 1'b1, "R7 start while busy ignored", busy, 1);
      cyc++;
    end
    @(negedge clk);
    stepEn = 1'b0; start = 1'b0;
    #1;
    check(busy == 1'b0, "R6 idle after last", busy, 0);
    check(addrValid == 1'b0, "R6 no valid after last", addrValid, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    check(busy == 1'b0 && addrValid == 1'b0 && addrLast == 1'b0, "R1 reset idle", busy, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(busy == 1'b0, "R1 idle after reset release", busy, 0);
    stepEn = 1'b1;
    #1;
    check(addrValid == 1'b0, "R1 step ignored while idle", addrValid, 0);
    stepEn = 1'b0;

    // R4 R10: walk the vector table, back to back
    for (int v = 0; v < NV; v++)
      runBlock(VN[v], VF1[v], VF2[v], VPM[v], VGP[v], VDS[v]);

    // R8: coverage of the whole range for the smallest legal block
    runBlock(40, 3, 10, 1'b1, 1'b0, 1'b0);
    begin
      int missing = 0;
      for (int k = 0; k < 40; k++) if (!seen[k]) missing++;
      check(missing == 0, "R8 full permutation", missing, 0);
    end

    // R2: reset in mid-block returns to idle
    runBlock(48, 7, 12, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b1; blockLen = 13'd64; coefF1 = 13'd7; coefF2 = 13'd16;
    @(negedge clk);
    start = 1'b0; stepEn = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(busy == 1'b0, "R1 reset during block", busy, 0);
    stepEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    runBlock(56, 19, 42, 1'b1, 1'b1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule